// File: doc/BRIEF.md
# Vector Byte Window Extractor

This block takes two 128-bit source vectors and returns a 128-bit result. The result is a contiguous 16-byte window cut from the 32-byte concatenation of the two sources. Bytes are numbered upward from the least significant byte. The first source supplies bytes 0 to 15 of the concatenation and the second source supplies bytes 16 to 31. A 4-bit start offset selects where the window begins. The block is therefore a byte-granular funnel shifter spanning two operands, not a rotate of one operand.

A caller presents both sources, the offset and a one-cycle valid strobe. The result is captured in an output register and shows up one cycle later, together with its own valid flag. Between strobes the output register keeps its last result. The shifter core can be built as one multiplexer per output byte or as a logarithmic chain of byte-shift stages. A parameter chooses which, and both give the same result.

Top module: `vbx_extract_unit`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `res_valid` and `res_data` are cleared to zero at that edge.
- R2: `res_valid` equals the `in_valid` value sampled at the previous rising edge, for every cycle after reset is released.
- R3: When `win_start` is 0, the registered result equals `vec_a` unchanged.
- R4: For output byte positions i below 16 minus `win_start`, result byte i equals byte (i + `win_start`) of `vec_a`.
- R5: For output byte positions i at or above 16 minus `win_start`, result byte i equals byte (i + `win_start` − 16) of `vec_b`.
- R6: Byte k of a vector occupies bits [8k+7:8k], so byte 0 is the least significant byte. `win_start` is an unsigned 4-bit value covering 0 to 15.
- R7: A cycle with `in_valid` low leaves `res_data` unchanged, whatever values the data and offset inputs carry in that cycle.
- R8: For every offset from 0 to 15, the result equals the low 128 bits of {`vec_b`, `vec_a`} shifted right by 8 × `win_start` bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Strobe that marks a request to capture |
| vec_a | input | 128 | First source; supplies the low 16 bytes of the concatenation |
| vec_b | input | 128 | Second source; supplies the high 16 bytes of the concatenation |
| win_start | input | 4 | Index of the first byte of the window within the concatenation |
| res_valid | output | 1 | One cycle after an accepted strobe |
| res_data | output | 128 | Registered 16-byte window |

## Verification
The properties assume that the sources and the offset are stable and known in every cycle in which `in_valid` is high. They compare the edge bytes of the result, byte 0 and byte 15, against the inputs sampled one cycle earlier. They also assume that any cycle without a strobe must leave the result register untouched. The stimulus drives all inputs at the falling edge, so every value is settled before it is sampled. It sweeps all sixteen offsets with structured and random byte patterns. It also changes data and offset during idle cycles to exercise the hold behaviour.

// File: rtl/vbx_pkg.sv
// Package: shared constants and types for the vector byte window extractor.
// Assumes byte lanes of equal width and a power-of-two lane count.
package vbx_pkg;
    // Selects how the funnel core is built.
    typedef enum logic [0:0] {
        FUNNEL_LANE_MUX  = 1'b0,
        FUNNEL_LOG_SHIFT = 1'b1
    } funnel_arch_e;

    localparam int unsigned DEF_LANES     = 16;
    localparam int unsigned DEF_LANE_BITS = 8;
endpackage

// File: rtl/vbx_lane_mux.sv
// Module: vbx_lane_mux
// Produces one output byte of the window. It adds the lane's own position
// to the offset. The carry bit picks the source, and the low bits pick the
// byte inside that source.
// Assumes LANES is a power of two, so wrapping into the second source
// needs no subtraction.
module vbx_lane_mux #(
    parameter int unsigned LANES     = 16,
    parameter int unsigned LANE_BITS = 8,
    parameter int unsigned LANE_IDX  = 0,
    localparam int unsigned OFS_W    = $clog2(LANES),
    localparam int unsigned VW       = LANES * LANE_BITS
) (
    input  logic [VW-1:0]        lo_vec,
    input  logic [VW-1:0]        hi_vec,
    input  logic [OFS_W-1:0]     ofs,
    output logic [LANE_BITS-1:0] lane_out
);
    localparam logic [OFS_W:0] POS = (OFS_W+1)'(LANE_IDX);

    logic [OFS_W:0]   src_idx;
    logic [OFS_W-1:0] byte_sel;

    // Absolute byte index into the 2*LANES concatenation.
    always_comb begin
        src_idx  = POS + {1'b0, ofs};
        byte_sel = src_idx[OFS_W-1:0];
    end

    // Choose the source by the carry bit, then pick the byte.
    always_comb begin
        if (src_idx[OFS_W]) begin
            lane_out = hi_vec[byte_sel*LANE_BITS +: LANE_BITS];
        end else begin
            lane_out = lo_vec[byte_sel*LANE_BITS +: LANE_BITS];
        end
    end
endmodule

// File: rtl/vbx_log_stage.sv
// Module: vbx_log_stage
// One stage of a logarithmic right shifter. When enabled, it moves the
// vector down by a fixed number of bits. The output may be narrower than
// the input, and only the low OUT_W bits are kept.
// Assumes SH_BITS is less than IN_W.
module vbx_log_stage #(
    parameter int unsigned IN_W    = 256,
    parameter int unsigned OUT_W   = 256,
    parameter int unsigned SH_BITS = 8
) (
    input  logic [IN_W-1:0]  d,
    input  logic             en,
    output logic [OUT_W-1:0] q
);
    // Conditional fixed shift, then truncate to the output width.
    always_comb begin
        if (en) begin
            q = OUT_W'(d >> SH_BITS);
        end else begin
            q = OUT_W'(d);
        end
    end
endmodule

// File: rtl/vbx_funnel.sv
// Module: vbx_funnel
// Combinational byte funnel. It returns LANES bytes of {hi_vec, lo_vec}
// starting at byte ofs. ARCH picks between one mux per output byte and a
// chain of log2(LANES) byte-shift stages.
// Assumes LANES is a power of two.
module vbx_funnel
    import vbx_pkg::*;
#(
    parameter int unsigned  LANES     = DEF_LANES,
    parameter int unsigned  LANE_BITS = DEF_LANE_BITS,
    parameter funnel_arch_e ARCH      = FUNNEL_LANE_MUX,
    localparam int unsigned OFS_W     = $clog2(LANES),
    localparam int unsigned VW        = LANES * LANE_BITS
) (
    input  logic [VW-1:0]    lo_vec,
    input  logic [VW-1:0]    hi_vec,
    input  logic [OFS_W-1:0] ofs,
    output logic [VW-1:0]    win
);
    generate
        if (ARCH == FUNNEL_LANE_MUX) begin : g_lane_mux
            // Each output byte gets its own selector.
            for (genvar li = 0; li < LANES; li++) begin : g_lane
                vbx_lane_mux #(
                    .LANES    (LANES),
                    .LANE_BITS(LANE_BITS),
                    .LANE_IDX (li)
                ) u_lane (
                    .lo_vec  (lo_vec),
                    .hi_vec  (hi_vec),
                    .ofs     (ofs),
                    .lane_out(win[li*LANE_BITS +: LANE_BITS])
                );
            end
        end else begin : g_log_shift
            logic [2*VW-1:0] chain [OFS_W];
            // Stage s shifts by 2^s bytes when offset bit s is set.
            for (genvar s = 0; s < OFS_W; s++) begin : g_stage
                localparam int unsigned SHB = (1 << s) * LANE_BITS;
                if (s == 0 && OFS_W == 1) begin : g_only
                    vbx_log_stage #(.IN_W(2*VW), .OUT_W(VW), .SH_BITS(SHB)) u_st (
                        .d({hi_vec, lo_vec}), .en(ofs[s]), .q(win));
                end else if (s == 0) begin : g_first
                    vbx_log_stage #(.IN_W(2*VW), .OUT_W(2*VW), .SH_BITS(SHB)) u_st (
                        .d({hi_vec, lo_vec}), .en(ofs[s]), .q(chain[s]));
                end else if (s == OFS_W - 1) begin : g_last
                    vbx_log_stage #(.IN_W(2*VW), .OUT_W(VW), .SH_BITS(SHB)) u_st (
                        .d(chain[s-1]), .en(ofs[s]), .q(win));
                end else begin : g_mid
                    vbx_log_stage #(.IN_W(2*VW), .OUT_W(2*VW), .SH_BITS(SHB)) u_st (
                        .d(chain[s-1]), .en(ofs[s]), .q(chain[s]));
                end
            end
        end
    endgenerate
endmodule

// File: rtl/vbx_out_stage.sv
// Module: vbx_out_stage
// Output register. It loads the window on a strobe and holds it otherwise.
// The valid flag is the strobe delayed by one cycle.
// Assumes a synchronous active-low reset.
module vbx_out_stage #(
    parameter int unsigned VW = 128
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [VW-1:0] d,
    output logic          q_valid,
    output logic [VW-1:0] q
);
    // Delay the strobe by one cycle to form the result flag.
    always_ff @(posedge clk) begin
        if (!rst_n) q_valid <= 1'b0;
        else        q_valid <= load;
    end

    // Capture the window only on a strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    q <= '0;
        else if (load) q <= d;
    end
endmodule

// File: rtl/vbx_extract_unit.sv
// Module: vbx_extract_unit (top)
// Extracts a LANES-byte window from the concatenation {vec_b, vec_a},
// starting at byte win_start. The result is registered one cycle after
// in_valid.
// Assumes the inputs are stable and known when in_valid is high, and that
// LANES is a power of two.
module vbx_extract_unit
    import vbx_pkg::*;
#(
    parameter int unsigned  LANES     = DEF_LANES,
    parameter int unsigned  LANE_BITS = DEF_LANE_BITS,
    parameter funnel_arch_e ARCH      = FUNNEL_LANE_MUX,
    localparam int unsigned OFS_W     = $clog2(LANES),
    localparam int unsigned VW        = LANES * LANE_BITS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [VW-1:0]    vec_a,
    input  logic [VW-1:0]    vec_b,
    input  logic [OFS_W-1:0] win_start,
    output logic             res_valid,
    output logic [VW-1:0]    res_data
);
    logic [VW-1:0] win_comb;

    vbx_funnel #(
        .LANES    (LANES),
        .LANE_BITS(LANE_BITS),
        .ARCH     (ARCH)
    ) u_funnel (
        .lo_vec(vec_a),
        .hi_vec(vec_b),
        .ofs   (win_start),
        .win   (win_comb)
    );

    vbx_out_stage #(.VW(VW)) u_out (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (in_valid),
        .d      (win_comb),
        .q_valid(res_valid),
        .q      (res_data)
    );
endmodule

// File: rtl/vbx_extract_chk.sv
// Module: vbx_extract_chk
// Property checker for vbx_extract_unit, attached to the top with bind.
// Assumes the inputs are known whenever in_valid is high.
module vbx_extract_chk #(
    parameter int unsigned LANES     = 16,
    parameter int unsigned LANE_BITS = 8,
    localparam int unsigned OFS_W    = $clog2(LANES),
    localparam int unsigned VW       = LANES * LANE_BITS
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [VW-1:0]    vec_a,
    input logic [VW-1:0]    vec_b,
    input logic [OFS_W-1:0] win_start,
    input logic             res_valid,
    input logic [VW-1:0]    res_data
);
    function automatic logic [LANE_BITS-1:0] pick(input logic [VW-1:0] v,
                                                  input logic [OFS_W-1:0] k);
        return v[k*LANE_BITS +: LANE_BITS];
    endfunction

    // R1: the registers are cleared in the cycle after reset
    p_reset_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!res_valid && res_data == '0));

    // R2: the result flag tracks the strobe one cycle late
    p_valid_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (res_valid == $past(in_valid)));

    // R3: a zero offset passes the first source through
    p_zero_ofs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(win_start) == '0)
        |-> (res_data == $past(vec_a)));

    // R4: result byte 0 comes from the first source at the offset
    p_low_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid))
        |-> (res_data[LANE_BITS-1:0] == pick($past(vec_a), $past(win_start))));

    // R5: the top result byte comes from the second source when the offset is non-zero
    p_top_byte_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(in_valid) && $past(win_start) != '0)
        |-> (res_data[VW-1 -: LANE_BITS] ==
             pick($past(vec_b), $past(win_start) - 1'b1)));

    // R7: an idle cycle keeps the result
    p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(in_valid)) |-> $stable(res_data));
endmodule

bind vbx_extract_unit vbx_extract_chk #(
    .LANES    (LANES),
    .LANE_BITS(LANE_BITS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .vec_a    (vec_a),
    .vec_b    (vec_b),
    .win_start(win_start),
    .res_valid(res_valid),
    .res_data (res_data)
);

// File: tb/tb_vbx_extract_unit.sv
`timescale 1ns/1ps
// Bench for vbx_extract_unit. It sweeps every offset against a reference
// built by shifting the concatenated sources.
module tb_vbx_extract_unit;
    logic         clk = 1'b0;
    logic         rst_n;
    logic         in_valid;
    logic [127:0] vec_a, vec_b;
    logic [3:0]   win_start;
    logic         res_valid;
    logic [127:0] res_data;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2.5 clk = ~clk;

    vbx_extract_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
        .vec_a(vec_a), .vec_b(vec_b), .win_start(win_start),
        .res_valid(res_valid), .res_data(res_data)
    );

    function automatic logic [127:0] ref_win(input logic [127:0] a,
                                             input logic [127:0] b,
                                             input int ofs);
        logic [255:0] cat;
        cat = {b, a} >> (8 * ofs);
        return cat[127:0];
    endfunction

    task automatic check(input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Present one request; return after the result has been registered.
    task automatic issue(input logic [127:0] a, input logic [127:0] b,
                         input int ofs);
        @(negedge clk);
        vec_a = a; vec_b = b; win_start = 4'(ofs); in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    function automatic logic [127:0] pattern(input int p, input int which);
        logic [127:0] v;
        for (int k = 0; k < 16; k++) begin
            case (p)
                0: v[8*k +: 8] = 8'(k + 16 * which);
                1: v[8*k +: 8] = 8'($urandom);
                2: v[8*k +: 8] = which ? 8'hFF : 8'h00;
                default: v[8*k +: 8] = which ? ~8'(8'hA5 ^ k) : 8'(8'hA5 ^ k);
            endcase
        end
        return v;
    endfunction

    initial begin
        logic [127:0] a, b, held;
        rst_n = 1'b0; in_valid = 1'b0; vec_a = '1; vec_b = '1; win_start = 4'd7;
        repeat (3) @(negedge clk);
        // R1: state while reset is held
        check("R1 valid", {127'd0, res_valid}, 128'd0);
        check("R1 data", res_data, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R2 idle after reset", {127'd0, res_valid}, 128'd0);

        // R8, R4, R5: every offset with several byte patterns
        for (int p = 0; p < 4; p++) begin
            for (int ofs = 0; ofs < 16; ofs++) begin
                a = pattern(p, 0); b = pattern(p, 1);
                issue(a, b, ofs);
                check("R2 valid", {127'd0, res_valid}, 128'd1);
                check("R8 window", res_data, ref_win(a, b, ofs));
            end
        end

        // R3: a zero offset returns the first source
        a = pattern(1, 0); b = pattern(1, 1);
        issue(a, b, 0);
        check("R3 passthrough", res_data, a);

        // R6: byte 0 is the least significant byte
        a = pattern(0, 0); b = pattern(0, 1);
        issue(a, b, 3);
        check("R6 byte0", {120'd0, res_data[7:0]}, 128'h03);
        check("R6 byte15", {120'd0, res_data[127:120]}, 128'h12);

        // R4 / R5: boundary offsets checked byte by byte
        issue(a, b, 1);
        check("R4 byte14 ofs1", {120'd0, res_data[119:112]}, 128'h0F);
        check("R5 byte15 ofs1", {120'd0, res_data[127:120]}, 128'h10);
        issue(a, b, 15);
        check("R4 byte0 ofs15", {120'd0, res_data[7:0]}, 128'h0F);
        check("R5 byte1 ofs15", {120'd0, res_data[15:8]}, 128'h10);
        check("R5 byte15 ofs15", {120'd0, res_data[127:120]}, 128'h1E);

        // R7: idle cycles with changing inputs leave the result alone
        held = res_data;
        @(negedge clk);
        vec_a = ~a; vec_b = ~b; win_start = 4'd9; in_valid = 1'b0;
        @(negedge clk);
        check("R7 hold", res_data, held);
        check("R2 no strobe", {127'd0, res_valid}, 128'd0);
        vec_a = pattern(1, 0); win_start = 4'd2;
        @(negedge clk);
        check("R7 hold again", res_data, held);

        // R1: reset in mid-run clears the result
        rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid-run clear", res_data, 128'd0);
        rst_n = 1'b1;
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end
endmodule